// File: doc/BRIEF.md
# Fourth-Order One-Bit Noise-Shaping Modulator

This block turns an oversampled, multi-bit signed audio stream into one density-modulated bit per channel. Every channel runs its own fourth-order loop: four saturating integrators in a chain and a one-bit quantizer. The quantizer decides from a weighted sum of the integrator states, and its decision is fed back into the first integrator as plus or minus full scale. The weights are powers of two, so each one costs only a shift.

The block advances only on cycles where the tick enable is high. The source drives one new sample per channel with each tick. The tick runs at 128 times the audio sample rate in base-rate operation and at 64 times in high-rate operation. A mode flag selects the weight set that suits each oversampling ratio. The output bit stays unchanged between ticks. A downstream switched-reference stage reads a 1 as a positive reference step and a 0 as a negative one.

Reset is synchronous and clears every integrator. The first tick after reset adds only half of each integrator's input. Because of this, a silent input settles at once into a clean 1,0,1,0 idle pattern.

Top module: `dsm4_mod`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `bits_o` becomes 0 and every integrator state becomes 0.
- R2: On the first tick after reset, every channel emits 1, whatever its input sample is.
- R3: On a clock edge with `tick_i` low, `bits_o` keeps its value, whatever `samples_i` and `hi_rate_i` do.
- R4: If only zero samples are applied after reset, each channel's output alternates 1,0,1,0,... starting at the first tick.
- R5: On each tick, channel c decides from its integrator states s0..s3 as they stood before the tick. It forms v = sum of (s_k arithmetically shifted right by w_k) and emits 1 when v >= 0, else 0. In base-rate mode (`hi_rate_i` = 0) the shifts are w = 0,2,5,9.
- R6: On each tick, s0 adds (x - F), where x is the signed sample and F = +2^(DW-1) after a 1 decision or -2^(DW-1) after a 0 decision of that same tick. Each following s_k adds the new value of s_(k-1). On the first tick after reset, every added quantity is first arithmetically shifted right by one.
- R7: After each addition, every integrator is limited to the range from -2^(DW-1+LIM_SHIFT) to +2^(DW-1+LIM_SHIFT).
- R8: Channel c takes its sample as a two's-complement value from `samples_i[c*DW +: DW]` and drives `bits_o[c]`. Channels do not affect one another.
- R9: For a constant input x that never drives the integrators into their limits, the fraction of 1s over a long run approaches (x + 2^(DW-1)) / 2^DW.
- R10: In high-rate mode (`hi_rate_i` = 1) the shifts are w = 0,1,3,6. The mode is sampled on each tick, so a change applies from the next tick on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Modulator tick enable; one sample per channel is taken on each tick |
| hi_rate_i | input | 1 | 0 selects base-rate weights, 1 selects high-rate weights |
| samples_i | input | NUM_CH*DW | Signed input sample of each channel, channel c in bits c*DW +: DW |
| bits_o | output | NUM_CH | One-bit modulator output of each channel, 1 meaning a positive reference step |

## Verification
An all-zero input from reset exposes the first-tick half step and the decision threshold: any error in either breaks the exact alternating idle pattern. Moderate constant inputs of opposite sign on the two channels check the decision and update rules tick by tick against a reference model. They also check that the ones density follows the input and that the channels stay separate. Full-scale positive and negative inputs drive the integrators into their limits, so a missing or wrong clamp shows up in the bit sequence. A ramp in high-rate mode, with the mode toggled mid-run, separates the two weight sets. A stretch of idle cycles with changing inputs and a toggling mode flag confirms that nothing moves without a tick.

// File: rtl/dsm4_pkg.sv
package dsm4_pkg;

   // Feed-forward weight of integrator stage k, as a right-shift amount.
   // Base-rate: 0,2,5,9,...  High-rate (half the oversampling): 0,1,3,6,...
   function automatic int ff_shift(input bit hi_rate, input int stage);
      return hi_rate ? (stage * (stage + 1)) / 2 : (stage * (stage + 3)) / 2;
   endfunction

   // Width of an integrator state: sample width plus limit headroom plus
   // guard bits so that state + input never wraps before the clamp.
   function automatic int state_width(input int dw, input int lim_shift);
      return dw + lim_shift + 3;
   endfunction

endpackage

// File: rtl/dsm4_integ.sv
module dsm4_integ #(
   parameter int SW      = 21,
   parameter int LIM_EXP = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic                 half_i,
   input  logic signed [SW-1:0] in_i,
   output logic signed [SW-1:0] nxt_o,
   output logic signed [SW-1:0] acc_o
);

   localparam int EW = SW + 1;
   localparam logic signed [EW-1:0] POS_LIM =
      {{(EW - LIM_EXP - 1){1'b0}}, 1'b1, {LIM_EXP{1'b0}}};
   localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM;

   logic signed [SW-1:0] add;
   logic signed [EW-1:0] sum;

   // First tick after reset integrates half the input (trapezoidal start).
   assign add = half_i ? (in_i >>> 1) : in_i;
   assign sum = $signed({acc_o[SW-1], acc_o}) + $signed({add[SW-1], add});

   always_comb begin
      if (sum > POS_LIM)
         nxt_o = POS_LIM[SW-1:0];
      else if (sum < NEG_LIM)
         nxt_o = NEG_LIM[SW-1:0];
      else
         nxt_o = sum[SW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_o <= '0;
      else if (step_i)
         acc_o <= nxt_o;
   end

endmodule

// File: rtl/dsm4_quant.sv
module dsm4_quant #(
   parameter int SW    = 21,
   parameter int ORDER = 4
) (
   input  logic                  hi_rate_i,
   input  logic [ORDER*SW-1:0]   st_i,
   output logic                  one_o
);

   localparam int QW = SW + 3;

   logic signed [QW-1:0] term [ORDER];
   logic signed [QW-1:0] total;

   for (genvar k = 0; k < ORDER; k++) begin : g_term
      localparam int SB = dsm4_pkg::ff_shift(1'b0, k);
      localparam int SH = dsm4_pkg::ff_shift(1'b1, k);
      logic signed [SW-1:0] st;
      logic signed [SW-1:0] t_base;
      logic signed [SW-1:0] t_high;
      assign st     = st_i[k*SW +: SW];
      assign t_base = st >>> SB;
      assign t_high = st >>> SH;
      assign term[k] = hi_rate_i ? {{3{t_high[SW-1]}}, t_high}
                                 : {{3{t_base[SW-1]}}, t_base};
   end

   always_comb begin
      total = '0;
      for (int k = 0; k < ORDER; k++)
         total = total + term[k];
      one_o = ~total[QW-1];
   end

endmodule

// File: rtl/dsm4_chan.sv
module dsm4_chan #(
   parameter int DW        = 16,
   parameter int ORDER     = 4,
   parameter int LIM_SHIFT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          hi_rate_i,
   input  logic [DW-1:0] x_i,
   output logic          bit_o
);

   localparam int SW      = dsm4_pkg::state_width(DW, LIM_SHIFT);
   localparam int LIM_EXP = DW - 1 + LIM_SHIFT;
   localparam logic signed [SW-1:0] FULL = {{(SW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

   logic                  first_q;
   logic                  one;
   logic signed [SW-1:0]  xs;
   logic signed [SW-1:0]  fb;
   logic signed [SW-1:0]  err;
   logic [ORDER*SW-1:0]   st_flat;
   logic signed [SW-1:0]  nxt [ORDER];
   logic signed [SW-1:0]  acc [ORDER];

   assign xs  = {{(SW-DW){x_i[DW-1]}}, x_i};
   assign fb  = one ? FULL : -FULL;
   assign err = xs - fb;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic signed [SW-1:0] stage_in;
      if (k == 0) begin : g_head
         assign stage_in = err;
      end else begin : g_link
         assign stage_in = nxt[k-1];
      end
      dsm4_integ #(.SW(SW), .LIM_EXP(LIM_EXP)) u_integ (
         .clk    (clk),
         .rst_n  (rst_n),
         .step_i (tick_i),
         .half_i (first_q),
         .in_i   (stage_in),
         .nxt_o  (nxt[k]),
         .acc_o  (acc[k])
      );
      assign st_flat[k*SW +: SW] = acc[k];
   end

   dsm4_quant #(.SW(SW), .ORDER(ORDER)) u_quant (
      .hi_rate_i (hi_rate_i),
      .st_i      (st_flat),
      .one_o     (one)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_o   <= 1'b0;
         first_q <= 1'b1;
      end else if (tick_i) begin
         bit_o   <= one;
         first_q <= 1'b0;
      end
   end

endmodule

// File: rtl/dsm4_mod.sv
module dsm4_mod #(
   parameter int NUM_CH    = 2,
   parameter int DW        = 16,
   parameter int ORDER     = 4,
   parameter int LIM_SHIFT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 hi_rate_i,
   input  logic [NUM_CH*DW-1:0] samples_i,
   output logic [NUM_CH-1:0]    bits_o
);

   localparam int SW = dsm4_pkg::state_width(DW, LIM_SHIFT);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dsm4_mod: NUM_CH must be at least 1");
   end
   if (DW < 4 || DW > 32) begin : g_bad_dw
      $error("dsm4_mod: DW must lie in 4..32");
   end
   if (ORDER < 1 || ORDER > 6) begin : g_bad_order
      $error("dsm4_mod: ORDER must lie in 1..6");
   end
   if (LIM_SHIFT < 1 || LIM_SHIFT > 4) begin : g_bad_lim
      $error("dsm4_mod: LIM_SHIFT must lie in 1..4");
   end
   if (dsm4_pkg::ff_shift(1'b0, ORDER-1) >= SW) begin : g_bad_shift
      $error("dsm4_mod: feed-forward shift exceeds state width");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dsm4_chan #(.DW(DW), .ORDER(ORDER), .LIM_SHIFT(LIM_SHIFT)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick_i),
         .hi_rate_i (hi_rate_i),
         .x_i       (samples_i[c*DW +: DW]),
         .bit_o     (bits_o[c])
      );
   end

endmodule

// File: rtl/dsm4_mod_chk.sv
module dsm4_mod_chk #(
   parameter int NUM_CH = 2,
   parameter int DW     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_i,
   input logic [NUM_CH*DW-1:0] samples_i,
   input logic [NUM_CH-1:0]    bits_o
);

   logic started_q;
   logic idle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         idle_q    <= 1'b1;
      end else if (tick_i) begin
         started_q <= 1'b1;
         if (samples_i != '0)
            idle_q <= 1'b0;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> bits_o == '0); // R1

   AST_FIRST_TICK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !started_q) |=> bits_o == '1); // R2

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(bits_o)); // R3

   AST_IDLE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && started_q && idle_q && samples_i == '0) |=> bits_o == ~$past(bits_o)); // R4

endmodule

bind dsm4_mod dsm4_mod_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .samples_i (samples_i),
   .bits_o    (bits_o)
);

// File: tb/dsm4_mod_tb.sv
module dsm4_mod_tb;

   localparam int DW    = 16;
   localparam int ORDER = 4;
   localparam int LS    = 2;
   localparam int NCH   = 2;
   localparam longint FS  = longint'(1) << (DW - 1);
   localparam longint LIM = longint'(1) << (DW - 1 + LS);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n = 1'b0;
   logic               tick  = 1'b0;
   logic               hi    = 1'b0;
   logic [NCH*DW-1:0]  samples = '0;
   logic [NCH-1:0]     bits;

   int  errs   = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   longint ms [NCH][ORDER];
   bit     mfirst [NCH];
   bit     mhi = 1'b0;

   dsm4_mod #(.NUM_CH(NCH), .DW(DW), .ORDER(ORDER), .LIM_SHIFT(LS)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .hi_rate_i (hi),
      .samples_i (samples),
      .bits_o    (bits)
   );

   function automatic int wsh(bit h, int k);
      return h ? (k * (k + 1)) / 2 : (k * (k + 3)) / 2;
   endfunction

   // Reference loop built from R5, R6, R7 and R10.
   function automatic bit mstep(int ch, longint x);
      longint v = 0;
      longint in;
      longint s;
      bit     y;
      for (int k = 0; k < ORDER; k++) v += ms[ch][k] >>> wsh(mhi, k);
      y  = (v >= 0);
      in = x - (y ? FS : -FS);
      for (int k = 0; k < ORDER; k++) begin
         if (mfirst[ch]) in = in >>> 1;
         s = ms[ch][k] + in;
         if (s > LIM) s = LIM;
         if (s < -LIM) s = -LIM;
         ms[ch][k] = s;
         in = s;
      end
      mfirst[ch] = 1'b0;
      return y;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_tick(input longint x0, input longint x1,
                          output logic [NCH-1:0] got, output logic [NCH-1:0] exp);
      @(negedge clk);
      samples = {DW'(x1), DW'(x0)};
      hi      = mhi;
      tick    = 1'b1;
      @(negedge clk);
      tick    = 1'b0;
      exp[0]  = mstep(0, x0);
      exp[1]  = mstep(1, x1);
      got     = bits;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick  = 1'b0;
      repeat (3) @(negedge clk);
      chk(bits == '0, "R1 reset output", longint'(bits), 0);
      for (int c = 0; c < NCH; c++) begin
         mfirst[c] = 1'b1;
         for (int k = 0; k < ORDER; k++) ms[c][k] = 0;
      end
      rst_n = 1'b1;
   endtask

   task automatic t_idle();
      logic [NCH-1:0] got, exp, prev;
      t_reset();
      mhi  = 1'b0;
      prev = '0;
      for (int i = 0; i < 24; i++) begin
         do_tick(0, 0, got, exp);
         if (i == 0) chk(got == '1, "R2 first tick ones", longint'(got), 3);
         else        chk(got == ~prev, "R4 idle alternation", longint'(got), longint'(~prev));
         chk(got == exp, "R5 R6 idle model", longint'(got), longint'(exp));
         prev = got;
      end
   endtask

   task automatic t_hold();
      logic [NCH-1:0] got, exp, held;
      for (int i = 0; i < 5; i++) do_tick(5000, -7000, got, exp);
      held = bits;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         samples = {DW'(i * 999 + 1), DW'(-i * 1234 - 3)};
         hi      = ~hi;
         chk(bits == held, "R3 hold without tick", longint'(bits), longint'(held));
      end
      hi = mhi;
   endtask

   task automatic t_run(input longint x0, input longint x1, input int n,
                        input string req, input bit dens);
      logic [NCH-1:0] got, exp;
      int ones0 = 0, ones1 = 0;
      longint e0, e1;
      for (int i = 0; i < n; i++) begin
         do_tick(x0, x1, got, exp);
         chk(got == exp, req, longint'(got), longint'(exp));
         ones0 += got[0];
         ones1 += got[1];
      end
      if (dens) begin
         e0 = ((x0 + FS) * 1000) / (2 * FS);
         e1 = ((x1 + FS) * 1000) / (2 * FS);
         chk((ones0 * 1000 / n) >= e0 - 40 && (ones0 * 1000 / n) <= e0 + 40,
             "R9 density ch0 permille", ones0 * 1000 / n, e0);
         chk((ones1 * 1000 / n) >= e1 - 40 && (ones1 * 1000 / n) <= e1 + 40,
             "R9 density ch1 permille", ones1 * 1000 / n, e1);
      end
   endtask

   task automatic t_mode();
      logic [NCH-1:0] got, exp;
      longint x;
      t_reset();
      mhi = 1'b1;
      for (int i = 0; i < 300; i++) begin
         if (i == 100) mhi = 1'b0;
         if (i == 200) mhi = 1'b1;
         x = ((i % 64) - 32) * 600;
         do_tick(x, -x / 2, got, exp);
         chk(got == exp, "R10 high-rate weights", longint'(got), longint'(exp));
      end
      mhi = 1'b0;
   endtask

   task automatic t_rereset();
      logic [NCH-1:0] got, exp;
      t_run(20000, -20000, 7, "R6 pre-reset run", 1'b0);
      t_reset();
      do_tick(-20000, -30000, got, exp);
      chk(got == '1, "R2 first tick after re-reset", longint'(got), 3);
      chk(got == exp, "R6 re-reset half step", longint'(got), longint'(exp));
      t_run(-20000, -30000, 40, "R6 after re-reset", 1'b0);
   endtask

   initial begin
      t_idle();
      t_hold();
      t_reset();
      t_run(8192, 8192, 512, "R5 R6 quarter-scale", 1'b1);
      t_reset();
      t_run(12000, -12000, 512, "R8 opposite channels", 1'b1);
      t_reset();
      t_run(0, 9000, 64, "R8 silent neighbour", 1'b0);
      t_reset();
      t_run(32767, -32768, 300, "R7 full-scale clamp", 1'b0);
      t_mode();
      t_rereset();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule